// File: doc/BRIEF.md
# Amplitude Level Detector for Gain Control

The block watches a stream of signed samples and estimates what share of them have a magnitude above a programmable threshold. For each valid sample it forms a saturating absolute value and compares it with the threshold, which gives one bit per sample: 1 when the magnitude is strictly greater than the threshold, 0 otherwise. That bit feeds an unsigned first-order recursive averager. The averager's smoothing factor is a power of two, so the multiply becomes an arithmetic right shift.

The averager's output is a fixed-point fraction. An indicator of 1 carries a weight of 2^AW, so an average near the top of the AW-bit range means nearly every sample is over the threshold. An average of 0 means none are. Two programmable limits turn this fraction into requests for a gain stage: gain_down when the level sits above the high limit, and gain_up when it sits below the low limit. The gain stage itself is outside the block.

With the default parameters, the bench's checks assume IW=12, AW=16 and LGALPHA=4. The minimum sample is -2048, the maximum magnitude is 2047, and the fixed point of the averager under a constant 1 indicator lies in 65521..65535.

Top module: `agc_level_detect`

## Requirements
- R1: While rst_n is low, over_thr, avg_level, gain_up and gain_down are all 0.
- R2: The magnitude of a sample is its absolute value, taken as an unsigned IW-bit number. The most negative sample, -2^(IW-1), maps to 2^(IW-1)-1.
- R3: On the clock edge where in_valid is 1, over_thr is loaded with 1 if the magnitude is strictly greater than threshold (unsigned, IW bits), and with 0 if it is equal to or below threshold.
- R4: On the clock edge after the one that loaded over_thr, avg_level becomes avg + floor((over_thr*2^AW - avg) / 2^LGALPHA), with floor rounding toward minus infinity.
- R5: While in_valid is 0, over_thr holds its value. One edge later, avg_level also holds, whatever in_sample and threshold do.
- R6: Under a long run of indicators equal to 1, avg_level never decreases and never wraps. It settles at 2^AW - 2^LGALPHA + 1 or higher. Under indicators equal to 0, it never increases and decays to 0.
- R7: One edge after avg_level is strictly greater than limit_hi, gain_down is 1. Otherwise, gain_down is 0.
- R8: One edge after avg_level is strictly below limit_lo and not above limit_hi, gain_up is 1. Otherwise, gain_up is 0.
- R9: gain_up and gain_down are never 1 together. If the limits are set so that both conditions hold, gain_down wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_sample carries a new sample this cycle |
| in_sample | input | IW | Signed two's-complement sample |
| threshold | input | IW | Unsigned magnitude threshold |
| limit_hi | input | AW | Level above which gain_down is requested |
| limit_lo | input | AW | Level below which gain_up is requested |
| over_thr | output | 1 | Indicator for the most recent valid sample |
| avg_level | output | AW | Averaged fraction of samples over the threshold |
| gain_up | output | 1 | Request to raise the gain |
| gain_down | output | 1 | Request to lower the gain |

## Verification
The bench feeds the most negative sample with thresholds of 2046 and 2047. If the saturation were missing, the negated value would come out as -2048, which reads as 2048 or as a wrapped 0, and over_thr would take the wrong value in one of the two cases. It also feeds a magnitude exactly equal to the threshold, because a design that compared with "at least" instead of "greater than" would raise the indicator there.

Runs of several hundred 1 and 0 indicators drive the average to both ends. A logical shift in place of an arithmetic one would push the average up during decay. A target weighted one bit too high would wrap the average past the top. Idle gaps carry scrambled samples and thresholds, so an averager that updates without a strobe shows up as drift. Setting the low limit above the high limit shows whether gain_down keeps priority.

// File: rtl/agc_pkg.sv
package agc_pkg;

  // Gain request coded by the limit comparator
  typedef enum logic [1:0] {
    GAIN_HOLD = 2'b00,
    GAIN_UP   = 2'b01,
    GAIN_DOWN = 2'b10
  } gain_req_e;

endpackage

// File: rtl/agc_mag_cmp.sv
module agc_mag_cmp #(
  parameter int IW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_sample,
  input  logic        [IW-1:0] threshold,
  output logic                 over_q,
  output logic                 strobe_q
);

  localparam logic signed [IW-1:0] SMIN = {1'b1, {(IW-1){1'b0}}};
  localparam logic        [IW-1:0] UMAX = {1'b0, {(IW-1){1'b1}}};

  // Saturating magnitude: the most negative value clips to the largest positive
  function automatic logic [IW-1:0] abs_sat(input logic signed [IW-1:0] x);
    logic signed [IW-1:0] neg;
    if (!x[IW-1]) return x;
    if (x == SMIN) return UMAX;
    neg = -x;
    return neg;
  endfunction

  logic [IW-1:0] mag;
  logic          above;

  always_comb begin
    mag   = abs_sat(in_sample);
    above = (mag > threshold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= in_valid;
      if (in_valid) over_q <= above;
    end
  end

endmodule

// File: rtl/agc_avg.sv
module agc_avg #(
  parameter int AW      = 16,
  parameter int LGALPHA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ind_vld,
  input  logic          ind,
  output logic [AW-1:0] avg_q
);

  localparam int XW = AW + 2;

  // One averager step: avg + ((ind * 2^AW) - avg) >>> LGALPHA
  function automatic logic [AW-1:0] avg_step(input logic [AW-1:0] avg,
                                             input logic          bit_in);
    logic signed [XW-1:0] target;
    logic signed [XW-1:0] diff;
    logic signed [XW-1:0] adj;
    logic signed [XW-1:0] sum;
    target = bit_in ? $signed({2'b01, {AW{1'b0}}}) : '0;
    diff   = target - $signed({2'b00, avg});
    adj    = diff >>> LGALPHA;
    sum    = $signed({2'b00, avg}) + adj;
    return sum[AW-1:0];
  endfunction

  logic [AW-1:0] avg_nxt;

  always_comb avg_nxt = avg_step(avg_q, ind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       avg_q <= '0;
    else if (ind_vld) avg_q <= avg_nxt;
  end

endmodule

// File: rtl/agc_limit_cmp.sv
module agc_limit_cmp
  import agc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] level,
  input  logic [AW-1:0] lim_hi,
  input  logic [AW-1:0] lim_lo,
  output gain_req_e     req_q
);

  // Down has priority over up when the limits overlap
  function automatic gain_req_e decide(input logic [AW-1:0] lvl,
                                       input logic [AW-1:0] hi,
                                       input logic [AW-1:0] lo);
    if (lvl > hi) return GAIN_DOWN;
    if (lvl < lo) return GAIN_UP;
    return GAIN_HOLD;
  endfunction

  gain_req_e req_nxt;

  always_comb req_nxt = decide(level, lim_hi, lim_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= GAIN_HOLD;
    else        req_q <= req_nxt;
  end

endmodule

// File: rtl/agc_level_detect.sv
module agc_level_detect
  import agc_pkg::*;
#(
  parameter int IW      = 12,
  parameter int AW      = 16,
  parameter int LGALPHA = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_sample,
  input  logic        [IW-1:0] threshold,
  input  logic        [AW-1:0] limit_hi,
  input  logic        [AW-1:0] limit_lo,
  output logic                 over_thr,
  output logic        [AW-1:0] avg_level,
  output logic                 gain_up,
  output logic                 gain_down
);

  // Named internal events, visible to the bound checker
  logic      ind_vld;
  gain_req_e gain_req;

  agc_mag_cmp #(.IW(IW)) u_mag (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .threshold (threshold),
    .over_q    (over_thr),
    .strobe_q  (ind_vld)
  );

  agc_avg #(.AW(AW), .LGALPHA(LGALPHA)) u_avg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ind_vld (ind_vld),
    .ind     (over_thr),
    .avg_q   (avg_level)
  );

  agc_limit_cmp #(.AW(AW)) u_lim (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (avg_level),
    .lim_hi (limit_hi),
    .lim_lo (limit_lo),
    .req_q  (gain_req)
  );

  assign gain_up   = (gain_req == GAIN_UP);
  assign gain_down = (gain_req == GAIN_DOWN);

endmodule

// File: rtl/agc_level_chk.sv
module agc_level_chk #(
  parameter int IW = 12,
  parameter int AW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [IW-1:0] in_sample,
  input logic        [IW-1:0] threshold,
  input logic        [AW-1:0] limit_hi,
  input logic        [AW-1:0] limit_lo,
  input logic                 over_thr,
  input logic        [AW-1:0] avg_level,
  input logic                 gain_up,
  input logic                 gain_down,
  input logic                 ind_vld
);

  localparam logic signed [IW-1:0] SMIN = {1'b1, {(IW-1){1'b0}}};
  localparam logic        [IW-1:0] UMAX = {1'b0, {(IW-1){1'b1}}};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!over_thr && avg_level == '0 && !gain_up && !gain_down));

  // R2
  min_sample_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample == SMIN && threshold < UMAX) |=> over_thr);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(over_thr));

  // R5
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_vld |=> $stable(avg_level));

  // R6
  avg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_vld && over_thr) |=> (avg_level >= $past(avg_level)));

  // R6
  avg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_vld && !over_thr) |=> (avg_level <= $past(avg_level)));

  // R7
  gain_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_level > limit_hi) |=> gain_down);

  // R8
  gain_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_level < limit_lo && avg_level <= limit_hi) |=> gain_up);

  // R9
  no_both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gain_up && gain_down));

endmodule

bind agc_level_detect agc_level_chk #(.IW(IW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .threshold (threshold),
  .limit_hi  (limit_hi),
  .limit_lo  (limit_lo),
  .over_thr  (over_thr),
  .avg_level (avg_level),
  .gain_up   (gain_up),
  .gain_down (gain_down),
  .ind_vld   (ind_vld)
);

// File: tb/test_agc_level_detect.sv
`timescale 1ns/1ps
module test_agc_level_detect;

  localparam int IW = 12;
  localparam int AW = 16;
  localparam int LG = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [IW-1:0] in_sample = '0;
  logic        [IW-1:0] threshold = 12'd1000;
  logic        [AW-1:0] limit_hi = 16'hC000;
  logic        [AW-1:0] limit_lo = 16'h4000;
  logic                 over_thr;
  logic        [AW-1:0] avg_level;
  logic                 gain_up;
  logic                 gain_down;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  agc_level_detect #(.IW(IW), .AW(AW), .LGALPHA(LG)) i_agc_level_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .threshold(threshold), .limit_hi(limit_hi), .limit_lo(limit_lo),
    .over_thr(over_thr), .avg_level(avg_level), .gain_up(gain_up),
    .gain_down(gain_down));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, written with integers
  longint m_over = 0, m_vld = 0, m_avg = 0, m_up = 0, m_dn = 0;
  bit     model_on = 1'b0;

  function automatic longint ref_mag(longint x);
    if (x >= 0) return x;
    if (-x > (1 << (IW-1)) - 1) return (1 << (IW-1)) - 1;
    return -x;
  endfunction

  function automatic longint floor_div(longint a, longint d);
    if (a >= 0) return a / d;
    return -((-a + d - 1) / d);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_over = 0; m_vld = 0; m_avg = 0; m_up = 0; m_dn = 0;
    end else begin
      longint n_over, n_avg, n_up, n_dn;
      n_dn   = (m_avg > limit_hi) ? 1 : 0;
      n_up   = (n_dn == 0 && m_avg < limit_lo) ? 1 : 0;
      n_avg  = m_vld ? m_avg + floor_div(m_over * (longint'(1) << AW) - m_avg,
                                         longint'(1) << LG) : m_avg;
      n_over = in_valid ? ((ref_mag(longint'(in_sample)) > threshold) ? 1 : 0)
                        : m_over;
      m_vld  = in_valid ? 1 : 0;
      m_over = n_over; m_avg = n_avg; m_up = n_up; m_dn = n_dn;
    end
  end

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      chk("R3 over_thr", over_thr, m_over);
      chk("R4 avg_level", avg_level, m_avg);
      chk("R7 gain_down", gain_down, m_dn);
      chk("R8 gain_up", gain_up, m_up);
      chk("R9 exclusive", (gain_up && gain_down) ? 1 : 0, 0);
    end
  end

  task automatic put(longint x);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = IW'(x);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = IW'(i * 377 - 1500);
    end
  endtask

  initial begin
    #50000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 over_thr", over_thr, 0);
    chk("R1 avg_level", avg_level, 0);
    chk("R1 gain_up", gain_up, 0);
    chk("R1 gain_down", gain_down, 0);
    rst_n = 1'b1;
    model_on = 1'b1;

    // R2: most negative sample against thresholds at and just below the maximum magnitude
    threshold = 12'd2046;
    put(-2048);
    idle(1);
    chk("R2 min sample over 2046", over_thr, 1);
    threshold = 12'd2047;
    put(-2048);
    idle(1);
    chk("R2 min sample not over 2047", over_thr, 0);

    // R3: equal to threshold is not over; mixed signs
    threshold = 12'd1000;
    put(1000);
    idle(1);
    chk("R3 equal not over", over_thr, 0);
    put(-1001);
    idle(1);
    chk("R3 negative above", over_thr, 1);
    put(1001); put(-999); put(0); put(2047);

    // R5: indicator and level hold while idle, threshold scrambled
    put(1500);
    idle(2);
    begin
      longint h_over, h_avg;
      h_over = over_thr;
      h_avg  = avg_level;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        threshold = IW'(i * 611);
        chk("R5 over_thr holds", over_thr, h_over);
        chk("R5 avg holds", avg_level, h_avg);
      end
      threshold = 12'd1000;
    end

    // R6: long run over threshold, with occasional gaps
    for (int i = 0; i < 400; i++) begin
      put((i % 2) ? 1800 : -1800);
      if (i % 37 == 0) idle(1);
    end
    idle(3);
    chk("R6 settles near full scale", (avg_level >= 65521) ? 1 : 0, 1);
    chk("R7 gain_down at full scale", gain_down, 1);

    // R9: overlapping limits, down must win
    limit_lo = 16'hFFFF;
    limit_hi = 16'h8000;
    idle(2);
    chk("R9 down wins", gain_down, 1);
    chk("R9 up suppressed", gain_up, 0);
    limit_lo = 16'h4000;
    limit_hi = 16'hC000;

    // R6: long run under threshold decays to zero
    for (int i = 0; i < 400; i++) put((i % 3) - 1);
    idle(3);
    chk("R6 decays to zero", avg_level, 0);
    chk("R8 gain_up at zero", gain_up, 1);

    // Mixed pattern: about one in four over
    for (int i = 0; i < 300; i++) put((i % 4 == 0) ? -1500 : 300);
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule